// File: doc/BRIEF.md
# Power Domain and Module Clock Sequencer

This block keeps a current operating state for every module in a small SoC and drives each module's clock enable and reset lines from it. Modules are grouped into power domains by a build-time map. Software writes a requested state into a module's control word. It then starts a transition by writing a command word with one bit per domain. The sequencer of that domain copies the requested states of its modules into their current states, and the per-module clock and reset outputs follow.

A domain that is powered off cannot take a transition straight away. Software first marks the domain as wanted on. The command then raises a pending flag toward the external supply, and that flag stays up until software writes the power-good confirmation bit. Only after that does the domain report power on and go on with the module update. Progress is visible through a busy word and a pending word. Both are indexed by domain.

The register port is a single write strobe with a byte address and a combinational read path. Module state codes use the low 5 bits: 0 = software reset, 1 = synchronous reset, 2 = disabled, 3 = enabled.

Top module: `power_sleep_ctl`

## Requirements
- R1: After reset every module reads state 2 with its clock enable at 0 and its reset output at 1. Domain 0 reads powered on and the other domains read off. The busy word, the pending word and `pwr_req` are all 0.
- R2: The module control word at 0x400+4*m reads back the requested state in bits [4:0]. The module status word at 0x800+4*m holds the current state in bits [4:0], and bit 12 is 1 exactly when that state is 1 or 3.
- R3: A command write (address 0x000) with bit d set, to a powered domain d, makes busy bit d (address 0x004) read 1 after that edge. The new current states show one edge later, the outputs change one edge after that, and busy bit d clears one edge after the outputs change.
- R4: `mod_clk_en[m]` is 1 exactly when the current state is 1 or 3. `mod_rst_n[m]` is 0 exactly when the current state is 0 or 1.
- R5: A command leaves unchanged the modules of other domains, and the modules whose requested state equals their current state.
- R6: A command to an unpowered domain d whose control word (0x100+4*d) has bit 0 set raises bit d of the pending word (0x008), bit d of `pwr_req` and busy bit d. All three hold while power-good is absent.
- R7: Setting bit 8 of the domain control word while the domain is pending clears the pending bit and sets bit 0 of the domain status word (0x200+4*d). The module update of R3 then follows, with busy clearing four edges after the power-good write.
- R8: A command to an unpowered domain whose control bit 0 is clear is ignored, with no busy or pending bit raised.
- R9: A command to a domain that is already busy is ignored, and requested states written after the commit are not applied.
- R10: Reads of the command address and of unmapped addresses return 0.
- R11: A single command word with several bits set starts every named domain in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mod_clk_en | output | NUM_MODULES | Per-module clock enable |
| mod_rst_n | output | NUM_MODULES | Per-module active-low reset |
| pwr_req | output | NUM_DOMAINS | Per-domain request toward the external supply |

## Verification
Two things can land in the same cycle. One is a fresh command write. The other is the commit or tail phase of a transition already running in that domain or in another one. The bench issues a second command to domain 0 in its own busy window, and writes a new requested state in the very cycle of the commit. It then checks that the later write is neither applied nor able to restart the sequence. A command word naming both domains at once is judged by the status words of both domains after the sequence ends.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int STW = 5;

  localparam logic [STW-1:0] ST_SWRST   = 5'd0;
  localparam logic [STW-1:0] ST_SYNCRST = 5'd1;
  localparam logic [STW-1:0] ST_DIS     = 5'd2;
  localparam logic [STW-1:0] ST_EN      = 5'd3;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PWAIT,
    SQ_COMMIT,
    SQ_HOLD,
    SQ_TAIL
  } seq_t;

  function automatic logic clk_running(input logic [STW-1:0] s);
    return (s == ST_SYNCRST) || (s == ST_EN);
  endfunction

  function automatic logic held_in_reset(input logic [STW-1:0] s);
    return (s == ST_SWRST) || (s == ST_SYNCRST);
  endfunction

endpackage

// File: rtl/psc_dom_seq.sv
module psc_dom_seq
  import psc_pkg::*;
#(
  parameter bit INIT_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic on_req,
  input  logic pwr_good,
  output logic powered,
  output logic busy,
  output logic pending,
  output logic commit
);

  seq_t st_q, st_d;
  logic pow_q, pow_d;
  logic pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    pow_d  = pow_q;
    pend_d = pend_q;
    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          if (pow_q) begin
            st_d = SQ_COMMIT;
          end else if (on_req) begin
            st_d   = SQ_PWAIT;
            pend_d = 1'b1;
          end
        end
      end
      SQ_PWAIT: begin
        if (pwr_good) begin
          pend_d = 1'b0;
          pow_d  = 1'b1;
          st_d   = SQ_COMMIT;
        end
      end
      SQ_COMMIT: st_d = SQ_HOLD;
      SQ_HOLD:   st_d = SQ_TAIL;
      SQ_TAIL:   st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pow_q  <= INIT_ON;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pow_q  <= pow_d;
      pend_q <= pend_d;
    end
  end

  assign powered = pow_q;
  assign pending = pend_q;
  assign busy    = (st_q != SQ_IDLE);
  assign commit  = (st_q == SQ_COMMIT);

  // R6: a pending domain is never reported as powered
  a_r6_pend_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !powered);

  // R6: pending holds until power-good arrives
  a_r6_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !pwr_good |=> pending);

  // R7: leaving the pending phase leaves the domain powered
  a_r7_power_up: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> powered);

  // R3: busy lasts exactly two cycles past the commit
  a_r3_busy_tail: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy ##1 busy ##1 !busy);

  // R9: a command to a busy domain never produces a commit
  a_r9_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !pending && go |=> !commit);

  // R8: an unpowered domain without an on request stays idle
  a_r8_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !powered && !on_req && go |=> !busy);

endmodule

// File: rtl/psc_mod_slot.sv
module psc_mod_slot
  import psc_pkg::*;
#(
  parameter logic [STW-1:0] RST_STATE = ST_DIS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic [STW-1:0] ctl_wdata,
  input  logic           commit,
  output logic [STW-1:0] req,
  output logic [STW-1:0] cur,
  output logic           clk_en,
  output logic           rst_out_n
);

  logic [STW-1:0] req_q, req_d;
  logic [STW-1:0] cur_q, cur_d;
  logic           en_q, en_d;
  logic           rn_q, rn_d;
  logic           take;

  always_comb begin
    take  = commit && (req_q != cur_q);
    req_d = ctl_wr ? ctl_wdata : req_q;
    cur_d = take ? req_q : cur_q;
    en_d  = clk_running(cur_q);
    rn_d  = !held_in_reset(cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= RST_STATE;
      cur_q <= RST_STATE;
      en_q  <= clk_running(RST_STATE);
      rn_q  <= !held_in_reset(RST_STATE);
    end else begin
      req_q <= req_d;
      cur_q <= cur_d;
      en_q  <= en_d;
      rn_q  <= rn_d;
    end
  end

  assign req       = req_q;
  assign cur       = cur_q;
  assign clk_en    = en_q;
  assign rst_out_n = rn_q;

  // R5: without a commit the current state does not move
  a_r5_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cur));

  // R3: a commit adopts the request present at the commit edge
  a_r3_commit_take: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cur == $past(req));

endmodule

// File: rtl/power_sleep_ctl.sv
module power_sleep_ctl
  import psc_pkg::*;
#(
  parameter int unsigned NUM_DOMAINS = 2,
  parameter int unsigned NUM_MODULES = 4,
  parameter int unsigned MOD_DOM [NUM_MODULES] = '{0, 0, 1, 1},
  parameter logic [NUM_DOMAINS-1:0] DOM_INIT_ON = 2'b01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [11:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [NUM_MODULES-1:0] mod_clk_en,
  output logic [NUM_MODULES-1:0] mod_rst_n,
  output logic [NUM_DOMAINS-1:0] pwr_req
);

  localparam logic [11:0] A_CMD      = 12'h000;
  localparam logic [11:0] A_BUSY     = 12'h004;
  localparam logic [11:0] A_PEND     = 12'h008;
  localparam int unsigned DCTL_BASE  = 32'h100;
  localparam int unsigned DSTAT_BASE = 32'h200;
  localparam int unsigned MCTL_BASE  = 32'h400;
  localparam int unsigned MSTAT_BASE = 32'h800;
  localparam int          ON_BIT     = 0;
  localparam int          PG_BIT     = 8;
  localparam int          RUN_BIT    = 12;

  logic [NUM_DOMAINS-1:0] go, powered, busy, pending, commit;
  logic [NUM_DOMAINS-1:0] on_q, on_d, pg_q, pg_d;
  logic [STW-1:0]         req [NUM_MODULES];
  logic [STW-1:0]         cur [NUM_MODULES];

  // domain control words: next-state and register processes
  always_comb begin
    on_d = on_q;
    pg_d = pg_q;
    for (int d = 0; d < int'(NUM_DOMAINS); d++) begin
      go[d] = reg_wr && (reg_addr == A_CMD) && reg_wdata[d];
      if (reg_wr && (reg_addr == 12'(DCTL_BASE + 4 * d))) begin
        on_d[d] = reg_wdata[ON_BIT];
        pg_d[d] = reg_wdata[PG_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= '0;
      pg_q <= '0;
    end else begin
      on_q <= on_d;
      pg_q <= pg_d;
    end
  end

  for (genvar d = 0; d < int'(NUM_DOMAINS); d++) begin : g_dom
    psc_dom_seq #(.INIT_ON(DOM_INIT_ON[d])) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go[d]),
      .on_req   (on_q[d]),
      .pwr_good (pg_q[d]),
      .powered  (powered[d]),
      .busy     (busy[d]),
      .pending  (pending[d]),
      .commit   (commit[d])
    );
  end

  for (genvar m = 0; m < int'(NUM_MODULES); m++) begin : g_mod
    logic slot_wr;
    assign slot_wr = reg_wr && (reg_addr == 12'(MCTL_BASE + 4 * m));
    psc_mod_slot #(.RST_STATE(ST_DIS)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (slot_wr),
      .ctl_wdata (reg_wdata[STW-1:0]),
      .commit    (commit[MOD_DOM[m]]),
      .req       (req[m]),
      .cur       (cur[m]),
      .clk_en    (mod_clk_en[m]),
      .rst_out_n (mod_rst_n[m])
    );
  end

  assign pwr_req = pending;

  // combinational read path, zero for anything unmapped
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_BUSY) reg_rdata[NUM_DOMAINS-1:0] = busy;
    if (reg_addr == A_PEND) reg_rdata[NUM_DOMAINS-1:0] = pending;
    for (int d = 0; d < int'(NUM_DOMAINS); d++) begin
      if (reg_addr == 12'(DCTL_BASE + 4 * d)) begin
        reg_rdata[ON_BIT] = on_q[d];
        reg_rdata[PG_BIT] = pg_q[d];
      end
      if (reg_addr == 12'(DSTAT_BASE + 4 * d)) reg_rdata[0] = powered[d];
    end
    for (int m = 0; m < int'(NUM_MODULES); m++) begin
      if (reg_addr == 12'(MCTL_BASE + 4 * m)) reg_rdata[STW-1:0] = req[m];
      if (reg_addr == 12'(MSTAT_BASE + 4 * m)) begin
        reg_rdata[STW-1:0] = cur[m];
        reg_rdata[RUN_BIT] = clk_running(cur[m]);
      end
    end
  end

  // R6: the supply request is raised only for unpowered domains
  a_r6_req_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_req & powered) == '0);

  // R11: every domain named in one command word leaves idle together
  a_r11_multi_start: assert property (@(posedge clk) disable iff (!rst_n)
    (go & ~busy & powered) != '0 |=> (($past(go & ~busy & powered) & ~busy) == '0));

endmodule

// File: tb/test_power_sleep_ctl.sv
module test_power_sleep_ctl;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  mod_clk_en;
  logic [3:0]  mod_rst_n;
  logic [1:0]  pwr_req;

  int total = 0;
  int bad   = 0;

  power_sleep_ctl i_power_sleep_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mod_clk_en (mod_clk_en),
    .mod_rst_n  (mod_rst_n),
    .pwr_req    (pwr_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // op: 0 write, 1 read and compare, 2 idle data cycles, 3 compare pwr_req
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 12'h004, 32'h0,      4'd1},  // R1 busy clear
    '{2'd1, 12'h800, 32'h2,      4'd1},  // R1 module disabled
    '{2'd1, 12'h200, 32'h1,      4'd1},  // R1 domain 0 on
    '{2'd1, 12'h204, 32'h0,      4'd1},  // R1 domain 1 off
    '{2'd0, 12'h400, 32'h3,      4'd0},
    '{2'd1, 12'h400, 32'h3,      4'd2},  // R2 request readback
    '{2'd0, 12'h000, 32'h1,      4'd0},
    '{2'd2, 12'h000, 32'd4,      4'd0},
    '{2'd1, 12'h800, 32'h1003,   4'd2},  // R2 enabled with clock bit
    '{2'd1, 12'h804, 32'h2,      4'd5},  // R5 unwritten module
    '{2'd0, 12'h404, 32'h1,      4'd0},
    '{2'd0, 12'h000, 32'h1,      4'd0},
    '{2'd2, 12'h000, 32'd4,      4'd0},
    '{2'd1, 12'h804, 32'h1001,   4'd2},  // R2 sync reset still clocked
    '{2'd1, 12'h808, 32'h2,      4'd5},  // R5 other domain
    '{2'd0, 12'h408, 32'h3,      4'd0},
    '{2'd0, 12'h000, 32'h2,      4'd0},
    '{2'd2, 12'h000, 32'd2,      4'd0},
    '{2'd1, 12'h004, 32'h0,      4'd8},  // R8 no busy
    '{2'd1, 12'h008, 32'h0,      4'd8},  // R8 no pending
    '{2'd1, 12'h808, 32'h2,      4'd8},  // R8 no state change
    '{2'd0, 12'h104, 32'h1,      4'd0},
    '{2'd0, 12'h000, 32'h2,      4'd0},
    '{2'd2, 12'h000, 32'd2,      4'd0},
    '{2'd1, 12'h008, 32'h2,      4'd6},  // R6 pending bit
    '{2'd1, 12'h004, 32'h2,      4'd6},  // R6 busy bit
    '{2'd3, 12'h000, 32'h2,      4'd6},  // R6 supply request
    '{2'd1, 12'h808, 32'h2,      4'd6},  // R6 waiting, no update
    '{2'd0, 12'h104, 32'h101,    4'd0},
    '{2'd2, 12'h000, 32'd5,      4'd0},
    '{2'd1, 12'h008, 32'h0,      4'd7},  // R7 pending cleared
    '{2'd3, 12'h000, 32'h0,      4'd7},  // R7 supply request dropped
    '{2'd1, 12'h204, 32'h1,      4'd7},  // R7 domain reports on
    '{2'd1, 12'h808, 32'h1003,   4'd7},  // R7 module updated
    '{2'd1, 12'h004, 32'h0,      4'd7},  // R7 busy cleared
    '{2'd1, 12'h0F0, 32'h0,      4'd10}, // R10 unmapped
    '{2'd1, 12'h000, 32'h0,      4'd10}, // R10 command reads zero
    '{2'd1, 12'h80C, 32'h2,      4'd5}   // R5 untouched module
  };

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: output pins and supply request after reset
    check(1, {28'b0, mod_clk_en}, 32'h0);
    check(1, {28'b0, mod_rst_n}, 32'hF);
    check(1, {30'b0, pwr_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: wr(VECS[i].addr, VECS[i].data);
        2'd1: begin
          rd(VECS[i].addr, v);
          check(int'(VECS[i].rq), v, VECS[i].data);
        end
        2'd2: repeat (int'(VECS[i].data)) @(negedge clk);
        default: begin
          #1;
          check(int'(VECS[i].rq), {30'b0, pwr_req}, VECS[i].data);
        end
      endcase
    end

    // R4: pins for states m0=3, m1=1, m2=3, m3=2
    #1;
    check(4, {28'b0, mod_clk_en}, 32'h7);
    check(4, {28'b0, mod_rst_n}, 32'hD);

    // R3: cycle-exact sequence, module 0 to software reset
    wr(12'h400, 32'h0);
    wr(12'h000, 32'h1);
    rd(12'h004, v);  check(3, v, 32'h1);
    rd(12'h800, v);  check(3, v, 32'h1003);
    @(negedge clk);
    rd(12'h800, v);  check(3, v, 32'h0);
    check(3, {31'b0, mod_clk_en[0]}, 32'h1);
    @(negedge clk);
    #1;
    check(4, {31'b0, mod_clk_en[0]}, 32'h0);
    check(4, {31'b0, mod_rst_n[0]}, 32'h0);
    rd(12'h004, v);  check(3, v, 32'h1);
    @(negedge clk);
    rd(12'h004, v);  check(3, v, 32'h0);

    // R9: late request written in the commit cycle and a command while busy
    wr(12'h404, 32'h3);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h1;
    @(negedge clk);
    reg_addr = 12'h400; reg_wdata = 32'h3;
    @(negedge clk);
    reg_addr = 12'h000; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (5) @(negedge clk);
    rd(12'h800, v);  check(9, v, 32'h0);
    rd(12'h804, v);  check(9, v, 32'h1003);
    rd(12'h004, v);  check(9, v, 32'h0);

    // R11: one command word starts both domains
    wr(12'h40C, 32'h1);
    wr(12'h000, 32'h3);
    rd(12'h004, v);  check(11, v, 32'h3);
    repeat (4) @(negedge clk);
    rd(12'h800, v);  check(11, v, 32'h1003);
    rd(12'h80C, v);  check(11, v, 32'h1001);
    rd(12'h808, v);  check(5, v, 32'h1003);

    finish_run();
  end

endmodule